// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block turns one 128-bit ciphertext block back into plaintext under a 128-bit key. It owns a single inverse-round datapath whose output feeds its own input through a state register, so one round is done per clock. Ciphertext and key arrive together over a narrow port: on each accepted cycle one 32-bit slice of each is shifted in. A block takes four accepted cycles to load.

The key enters as the cipher key, but decryption needs the last round key first. After loading, the core therefore steps the forward key expansion ten times to reach that key. During the inverse rounds it then walks the schedule backward one step per round, so no table of round keys is kept. When the last inverse round completes, the plaintext is shown on `pt` and `pt_valid` pulses for one cycle. The core is ready for the next block on the following cycle.

Top module: `aes_dec_core`

## Requirements
- R1: After reset `pt_valid` is 0, `in_ready` is 1 and `pt` is all zeros.
- R2: A word is taken on each rising edge where both `in_valid` and `in_ready` are 1. The first word taken is bits 127:96 of the ciphertext and of the key, and later words fill lower slices. Cycles with `in_valid` low in the middle of a load pause the load without corrupting it.
- R3: `pt_valid` rises exactly 20 clock edges after the edge that takes the fourth word. Ten edges are spent on key preparation and ten on inverse rounds.
- R4: Given ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a and key 000102030405060708090a0b0c0d0e0f, `pt` is 00112233445566778899aabbccddeeff while `pt_valid` is high. `pt_valid` stays high for one cycle only.
- R5: For any key and plaintext, loading the standard AES-128 encryption of that plaintext yields the plaintext. At completion, the internal round key has walked back to the loaded key.
- R6: `in_ready` is 0 from the edge after the fourth word until the edge after `pt_valid`. While `in_ready` is 0, `in_valid` and the data inputs are ignored.
- R7: While `in_ready` stays 1, `pt` holds the last plaintext produced.
- R8: A new block may start loading in the cycle right after `pt_valid`, and it decrypts correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Offers one word of ciphertext and key |
| in_ct | input | 32 | Ciphertext slice, most significant first |
| in_key | input | 32 | Key slice, most significant first |
| in_ready | output | 1 | High while the loader accepts words |
| pt_valid | output | 1 | One-cycle pulse when the plaintext is ready |
| pt | output | 128 | Recovered plaintext |

## Verification
The hardest thing to show from the ports is that the backward key walk really inverts the forward expansion on every step. One wrong backward step only shows up as a wrong plaintext, and only for some keys. The stimulus makes fresh random keys and plaintexts and runs them through the bench's own encryption model. The core must recover each plaintext exactly. Some blocks also carry stalled loads and stray `in_valid` pulses during the busy window, and some follow each other back to back.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;
  localparam int BLK_W      = 128;
  localparam int NUM_ROUNDS = 10;
  localparam int STEP_W     = $clog2(NUM_ROUNDS);

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_KEYPREP, ST_ROUND, ST_DONE} dec_state_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] x2, x3, x12, x15, x240;
    x2   = gf_mul(x, x);
    x3   = gf_mul(x2, x);
    x12  = gf_mul(gf_mul(x3, x3), gf_mul(x3, x3));
    x15  = gf_mul(x12, x3);
    x240 = gf_mul(x15, x15);
    x240 = gf_mul(x240, x240);
    x240 = gf_mul(x240, x240);
    x240 = gf_mul(x240, x240);
    return gf_mul(gf_mul(x240, x12), x2);
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] b, input int n);
    logic [7:0] r;
    r = b;
    for (int i = 0; i < 8; i++)
      if (i < n) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] y);
    return gf_inv(rol8(y, 1) ^ rol8(y, 3) ^ rol8(y, 6) ^ 8'h05);
  endfunction

  function automatic logic [7:0] rcon(input logic [STEP_W-1:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < NUM_ROUNDS; i++)
      if (i < int'(idx)) r = xtime(r);
    return r;
  endfunction

  function automatic logic [31:0] sub_rot(input logic [31:0] w);
    return {sbox_fwd(w[23:16]), sbox_fwd(w[15:8]), sbox_fwd(w[7:0]), sbox_fwd(w[31:24])};
  endfunction

  function automatic logic [127:0] key_fwd(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] n0, n1, n2, n3;
    n0 = k[127:96] ^ sub_rot(k[31:0]) ^ {rc, 24'h0};
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0]  ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic logic [127:0] key_bwd(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] p0, p1, p2, p3;
    p3 = k[31:0]  ^ k[63:32];
    p2 = k[63:32] ^ k[95:64];
    p1 = k[95:64] ^ k[127:96];
    p0 = k[127:96] ^ sub_rot(p3) ^ {rc, 24'h0};
    return {p0, p1, p2, p3};
  endfunction

  // byte n of a block sits at bits 127-8n .. 120-8n; column c holds bytes 4c..4c+3
  function automatic logic [127:0] inv_shift_rows(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c-r+4)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] inv_sub_bytes(input logic [127:0] s);
    logic [127:0] o;
    for (int n = 0; n < 16; n++) o[127-8*n -: 8] = sbox_inv(s[127-8*n -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] inv_mix_columns(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = gf_mul(a0,8'h0e)^gf_mul(a1,8'h0b)^gf_mul(a2,8'h0d)^gf_mul(a3,8'h09);
      o[119-32*c -: 8] = gf_mul(a0,8'h09)^gf_mul(a1,8'h0e)^gf_mul(a2,8'h0b)^gf_mul(a3,8'h0d);
      o[111-32*c -: 8] = gf_mul(a0,8'h0d)^gf_mul(a1,8'h09)^gf_mul(a2,8'h0e)^gf_mul(a3,8'h0b);
      o[103-32*c -: 8] = gf_mul(a0,8'h0b)^gf_mul(a1,8'h0d)^gf_mul(a2,8'h09)^gf_mul(a3,8'h0e);
    end
    return o;
  endfunction
endpackage

// File: rtl/aes_dec_loader.sv
module aes_dec_loader #(
  parameter int LOAD_W = 32,
  parameter int BLK_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic [LOAD_W-1:0] ct_word,
  input  logic [LOAD_W-1:0] key_word,
  output logic              accept,
  output logic              last_word,
  output logic [BLK_W-1:0]  ct_blk,
  output logic [BLK_W-1:0]  key_blk
);
  localparam int NWORDS = BLK_W / LOAD_W;
  localparam int CNT_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign accept    = in_valid & in_ready;
  assign last_word = accept && (cnt_q == CNT_W'(NWORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ct_blk  <= '0;
      key_blk <= '0;
    end else if (accept) begin
      cnt_q   <= last_word ? '0 : cnt_q + 1'b1;
      ct_blk  <= {ct_blk[BLK_W-LOAD_W-1:0], ct_word};
      key_blk <= {key_blk[BLK_W-LOAD_W-1:0], key_word};
    end
  end
endmodule

// File: rtl/aes_dec_keysched.sv
module aes_dec_keysched
  import aes_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_en,
  input  logic              bwd_en,
  input  logic              use_in,
  input  logic [STEP_W-1:0] rc_idx,
  input  logic [BLK_W-1:0]  key_in,
  output logic [BLK_W-1:0]  rk,
  output logic [BLK_W-1:0]  rk_fwd,
  output logic [BLK_W-1:0]  rk_bwd
);
  logic [BLK_W-1:0] rk_q;
  logic [7:0]       rc;

  assign rc     = rcon(rc_idx);
  assign rk_fwd = key_fwd(use_in ? key_in : rk_q, rc);
  assign rk_bwd = key_bwd(rk_q, rc);
  assign rk     = rk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      rk_q <= '0;
    else if (fwd_en) rk_q <= rk_fwd;
    else if (bwd_en) rk_q <= rk_bwd;
  end
endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round
  import aes_dec_pkg::*;
(
  input  logic [BLK_W-1:0] state_in,
  input  logic [BLK_W-1:0] round_key,
  input  logic             last,
  output logic [BLK_W-1:0] state_out
);
  logic [BLK_W-1:0] keyed;

  assign keyed     = inv_sub_bytes(inv_shift_rows(state_in)) ^ round_key;
  assign state_out = last ? keyed : inv_mix_columns(keyed);
endmodule

// File: rtl/aes_dec_core.sv
module aes_dec_core
  import aes_dec_pkg::*;
#(
  parameter int LOAD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LOAD_W-1:0] in_ct,
  input  logic [LOAD_W-1:0] in_key,
  output logic              in_ready,
  output logic              pt_valid,
  output logic [BLK_W-1:0]  pt
);
  dec_state_e        st_q;
  logic [STEP_W-1:0] step_q;
  logic [BLK_W-1:0]  blk_q;

  // named internal events
  logic             accept, load_done, keyprep_done, round_last;
  logic [BLK_W-1:0] ct_loaded, key_loaded, rk_now, rk_fwd, rk_bwd, round_out;
  logic             in_keyprep, in_round;

  assign in_ready     = (st_q == ST_IDLE) || (st_q == ST_LOAD);
  assign pt_valid     = (st_q == ST_DONE);
  assign pt           = blk_q;
  assign in_keyprep   = (st_q == ST_KEYPREP);
  assign in_round     = (st_q == ST_ROUND);
  assign keyprep_done = in_keyprep && (step_q == STEP_W'(NUM_ROUNDS-1));
  assign round_last   = in_round && (step_q == '0);

  aes_dec_loader #(.LOAD_W(LOAD_W), .BLK_W(BLK_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ct_word(in_ct), .key_word(in_key), .accept(accept), .last_word(load_done),
    .ct_blk(ct_loaded), .key_blk(key_loaded)
  );

  aes_dec_keysched u_ks (
    .clk(clk), .rst_n(rst_n), .fwd_en(in_keyprep), .bwd_en(in_round),
    .use_in(in_keyprep && (step_q == '0)), .rc_idx(step_q), .key_in(key_loaded),
    .rk(rk_now), .rk_fwd(rk_fwd), .rk_bwd(rk_bwd)
  );

  aes_dec_round u_round (
    .state_in(blk_q), .round_key(rk_bwd), .last(round_last), .state_out(round_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      blk_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_LOAD: begin
          if (load_done) begin
            st_q   <= ST_KEYPREP;
            step_q <= '0;
          end else if (accept) begin
            st_q <= ST_LOAD;
          end
        end
        ST_KEYPREP: begin
          if (keyprep_done) begin
            st_q  <= ST_ROUND;
            blk_q <= ct_loaded ^ rk_fwd;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_ROUND: begin
          blk_q <= round_out;
          if (round_last) st_q <= ST_DONE;
          else            step_q <= step_q - 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aes_dec_checker.sv
module aes_dec_checker
  import aes_dec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             load_done,
  input logic             pt_valid,
  input logic [BLK_W-1:0] pt,
  input logic [BLK_W-1:0] rk_now,
  input logic [BLK_W-1:0] key_loaded,
  input logic [BLK_W-1:0] ct_loaded
);
  localparam int LAT = 2 * NUM_ROUNDS + 1;
  logic [5:0] since_load;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    since_load <= '0;
    else if (load_done)                            since_load <= 6'd1;
    else if (since_load != '0 && since_load != '1) since_load <= since_load + 6'd1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |-> since_load == 6'(LAT));

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |=> !pt_valid);

  assert_key_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |-> rk_now == key_loaded);

  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !in_ready);

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && in_valid) |=> ($stable(ct_loaded) && $stable(key_loaded)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (!in_ready || $stable(pt)));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |=> in_ready);
endmodule

bind aes_dec_core aes_dec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .load_done(load_done), .pt_valid(pt_valid), .pt(pt), .rk_now(rk_now),
  .key_loaded(key_loaded), .ct_loaded(ct_loaded)
);

// File: tb/aes_dec_core_bench.sv
module aes_dec_core_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_ct = '0;
  logic [31:0]  in_key = '0;
  logic         in_ready, pt_valid;
  logic [127:0] pt;

  int checks = 0;
  int failures = 0;
  logic [7:0] sb [256];

  always #4 clk = ~clk;

  aes_dec_core u_aes_dec_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ct(in_ct), .in_key(in_key),
    .in_ready(in_ready), .pt_valid(pt_valid), .pt(pt)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // forward cipher model built on a table generated from a generator walk
  function automatic logic [127:0] encrypt(input logic [127:0] p, input logic [127:0] k);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] w [16];
    logic [7:0] rc, a0, a1, a2, a3;
    logic [127:0] o;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127-8*i -: 8];
      s[i] = p[127-8*i -: 8] ^ w[i];
    end
    for (int rnd = 1; rnd <= 10; rnd++) begin
      a0 = sb[w[13]] ^ rc; a1 = sb[w[14]]; a2 = sb[w[15]]; a3 = sb[w[12]];
      w[0] ^= a0; w[1] ^= a1; w[2] ^= a2; w[3] ^= a3;
      for (int i = 4; i < 16; i++) w[i] ^= w[i-4];
      rc = xt(rc);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          t[4*c+r] = sb[s[4*((c+r)%4)+r]];
      if (rnd < 10)
        for (int c = 0; c < 4; c++) begin
          a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
          t[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          t[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          t[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          t[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ w[i];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // loads one block; stall inserts a gap before word 2; junk toggles in_valid while busy
  task automatic run_block(input logic [127:0] ct, input logic [127:0] key,
                           input logic [127:0] exp_pt, input bit stall, input bit junk);
    for (int w = 0; w < 4; w++) begin
      if (stall && w == 2) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_ct    = ct[127-32*w -: 32];
      in_key   = key[127-32*w -: 32];
      @(negedge clk);
    end
    in_valid = junk;
    in_ct    = 32'hdeadbeef;
    in_key   = 32'h0badf00d;
    // now one edge past the fourth word
    check(!in_ready, "R6 busy after load", 128'(in_ready), 128'd0);
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      if (junk) in_valid = ~in_valid;
    end
    check(!pt_valid, "R3 no result before edge 20", 128'(pt_valid), 128'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check(pt_valid === 1'b1, "R3 result at edge 20", 128'(pt_valid), 128'd1);
    check(pt === exp_pt, "R5 plaintext", pt, exp_pt);
    @(negedge clk);
    check(!pt_valid, "R4 single-cycle pulse", 128'(pt_valid), 128'd0);
    check(in_ready === 1'b1 && pt === exp_pt, "R7 hold and R8 ready", pt, exp_pt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] p, q, x;
    logic [127:0] k, pl, c;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q ^= 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
    void'($urandom(32'h5eed_1234));

    // model sanity against the published vector
    c = encrypt(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f);
    check(c === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5 model", c, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pt_valid === 1'b0, "R1 valid low", 128'(pt_valid), 128'd0);
    check(in_ready === 1'b1, "R1 ready high", 128'(in_ready), 128'd1);
    check(pt === '0, "R1 pt zero", pt, 128'd0);

    // R4 directed vector, plain load
    run_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f,
              128'h00112233445566778899aabbccddeeff, 1'b0, 1'b0);
    // R2 stalled load and R6 stray valids, second known vector
    run_block(128'h3925841d02dc09fbdc118597196a0b32, 128'h2b7e151628aed2a6abf7158809cf4f3c,
              128'h3243f6a8885a308d313198a2e0370734, 1'b1, 1'b1);
    // corner keys: all zero and all ones (R5)
    run_block(encrypt('0, '0), '0, '0, 1'b0, 1'b0);
    run_block(encrypt('1, '1), '1, '1, 1'b1, 1'b0);
    // idle gap, then hold check R7 with in_valid low
    repeat (5) @(negedge clk);
    check(pt === '1, "R7 hold in idle", pt, '1);
    // random round trips, back to back (R8)
    for (int n = 0; n < 12; n++) begin
      k  = {$urandom, $urandom, $urandom, $urandom};
      pl = {$urandom, $urandom, $urandom, $urandom};
      run_block(encrypt(pl, k), k, pl, n[0], n[1]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule